// File: doc/BRIEF.md
# Sequential Access Slave Address Counter

This block sits on the slave side of a bus that supports sequential block transfers. A master gives an address once, at the start of a sequence. The master then strobes data repeatedly while the address strobe stays low. At the falling address strobe, the block checks the modifier code. If the code is one of the two sequential-access codes, the block loads the bus address into a local counter. The counter then steps forward by a fixed amount each time data strobe 0 rises. The sequence ends when the address strobe goes high.

The counter advances on every beat, including beats that belong to another board. This keeps every slave in step, so a block can straddle two boards or be interleaved across several. The current count is decoded against an inclusive base/limit window and an interleave lane match. The result drives an in-window select and a one-cycle per-beat enable, which a downstream responder uses to move data.

All bus inputs are active low and are assumed to be already synchronised to `clk_i`. Edges are found by comparing each input with its value at the previous clock. The data strobe must fall at least one clock after the address strobe falls.

Top module: `seq_slave_cnt`

## Requirements
- R1: After reset, `addr_o` is 0, and `sel_o`, `beat_o` and `wr_o` are 0.
- R2: When `as_n_i` is sampled low after being high, and `am_i` equals `SEQ_AM0` (default 6'h0B) or `SEQ_AM1` (default 6'h0F), `addr_o` takes `addr_i` at that edge. This happens whether or not the address is inside the window.
- R3: A falling address strobe with any other modifier code leaves `addr_o` unchanged. With such a code, `sel_o` and `beat_o` stay 0 for the rest of that strobe.
- R4: While a sequence is active and `as_n_i` is low, each rising edge of `ds0_n_i` adds `1 << STEP_SHIFT` to `addr_o`, exactly once per edge, on the clock after the edge is sampled.
- R5: The counter also advances on beats whose address lies outside this slave's window.
- R6: `sel_o` is 1 exactly when a sequence is active and the current count meets three conditions: it is at least `BASE`, it is at most `LIMIT`, and its lane field equals `ILV_OFS`. The lane field is bits [STEP_SHIFT +: ILV_LOG2]; with the defaults that is a[1] == 0.
- R7: `beat_o` is a one-cycle pulse on the clock after a falling `ds0_n_i` is sampled, but only if at that point the sequence is active, `as_n_i` is low and `sel_o` is 1. At the same edge, `wr_o` takes `~wr_n_i` (1 means write) and holds it until the next beat. Read and write beats may be mixed.
- R8: Sampling `as_n_i` high ends the sequence. `sel_o` drops to 0, and data strobe edges while `as_n_i` is high do not change `addr_o`.
- R9: The counter wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_n_i | input | 1 | Address strobe, active low |
| ds0_n_i | input | 1 | Data strobe 0, active low |
| wr_n_i | input | 1 | Read/write line, low for write |
| am_i | input | 6 | Address modifier code |
| addr_i | input | ADDR_W | Bus address |
| addr_o | output | ADDR_W | Current counter value |
| sel_o | output | 1 | Current count is in this slave's window |
| beat_o | output | 1 | One-cycle enable for an accepted beat |
| wr_o | output | 1 | Direction of the last accepted beat, 1 = write |

## Verification
A load appears on `addr_o` one clock after the falling address strobe is sampled. A counter step appears one clock after the rising data strobe is sampled. `beat_o` rises one clock after the falling data strobe is sampled, and `sel_o` follows `addr_o` in the same cycle. The bench drives every input on the falling clock edge and advances one full clock per strobe change. It compares against its own address and window model at the next falling edge, so each result is read exactly one register stage after its cause. Sequences are swept across the bottom and top of the window, through the interleave lanes and across the address wrap.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int AM_W = 6;
  typedef logic [AM_W-1:0] am_t;

  function automatic logic am_is_seq(am_t am, am_t code0, am_t code1);
    return (am == code0) || (am == code1);
  endfunction
endpackage

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  // bus strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
  assign rise_o = ~prev_q & sig_i;
endmodule

// File: rtl/seq_addr_cnt.sv
module seq_addr_cnt #(
  parameter int ADDR_W     = 16,
  parameter int STEP_SHIFT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] load_val_i,
  output logic [ADDR_W-1:0] cnt_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + STEP;  // wraps modulo 2^ADDR_W
  end
endmodule

// File: rtl/seq_win_dec.sv
module seq_win_dec #(
  parameter int          ADDR_W     = 16,
  parameter int          STEP_SHIFT = 1,
  parameter logic [ADDR_W-1:0] BASE  = 16'h0100,
  parameter logic [ADDR_W-1:0] LIMIT = 16'h01FF,
  parameter int          ILV_LOG2   = 1,
  parameter int          ILV_OFS    = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic in_range;
  logic lane_ok;

  assign in_range = (addr_i >= BASE) && (addr_i <= LIMIT);

  generate
    if (ILV_LOG2 > 0) begin : g_ilv
      localparam logic [ILV_LOG2-1:0] LANE = ILV_LOG2'(ILV_OFS);
      assign lane_ok = (addr_i[STEP_SHIFT +: ILV_LOG2] == LANE);
    end else begin : g_flat
      assign lane_ok = 1'b1;
    end
  endgenerate

  assign hit_o = in_range && lane_ok;
endmodule

// File: rtl/seq_slave_cnt.sv
module seq_slave_cnt
  import seq_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                STEP_SHIFT = 1,
  parameter logic [ADDR_W-1:0] BASE       = 16'h0100,
  parameter logic [ADDR_W-1:0] LIMIT      = 16'h01FF,
  parameter int                ILV_LOG2   = 1,
  parameter int                ILV_OFS    = 0,
  parameter logic [5:0]        SEQ_AM0    = 6'h0B,
  parameter logic [5:0]        SEQ_AM1    = 6'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_n_i,
  input  logic              ds0_n_i,
  input  logic              wr_n_i,
  input  logic [5:0]        am_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sel_o,
  output logic              beat_o,
  output logic              wr_o
);
  logic as_fall, as_rise_unused;
  logic ds_fall, ds_rise;
  logic act_q;
  logic load, inc, hit;

  seq_edge_det #(.W(1)) i_as_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(as_n_i),
    .fall_o(as_fall), .rise_o(as_rise_unused)
  );

  seq_edge_det #(.W(1)) i_ds_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(ds0_n_i),
    .fall_o(ds_fall), .rise_o(ds_rise)
  );

  assign load = as_fall && am_is_seq(am_t'(am_i), am_t'(SEQ_AM0), am_t'(SEQ_AM1));
  assign inc  = act_q && !as_n_i && ds_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= 1'b0;
    else if (as_n_i) act_q <= 1'b0;
    else if (load)   act_q <= 1'b1;
  end

  seq_addr_cnt #(.ADDR_W(ADDR_W), .STEP_SHIFT(STEP_SHIFT)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .inc_i(inc),
    .load_val_i(addr_i), .cnt_o(addr_o)
  );

  seq_win_dec #(
    .ADDR_W(ADDR_W), .STEP_SHIFT(STEP_SHIFT), .BASE(BASE), .LIMIT(LIMIT),
    .ILV_LOG2(ILV_LOG2), .ILV_OFS(ILV_OFS)
  ) i_win (
    .addr_i(addr_o), .hit_o(hit)
  );

  assign sel_o = act_q && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o <= 1'b0;
      wr_o   <= 1'b0;
    end else begin
      beat_o <= ds_fall && act_q && !as_n_i && sel_o;
      if (ds_fall && act_q && !as_n_i && sel_o) wr_o <= !wr_n_i;
    end
  end
endmodule

// File: rtl/seq_slave_cnt_chk.sv
module seq_slave_cnt_chk #(
  parameter int         ADDR_W     = 16,
  parameter int         STEP_SHIFT = 1,
  parameter logic [5:0] SEQ_AM0    = 6'h0B,
  parameter logic [5:0] SEQ_AM1    = 6'h0F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              as_n_i,
  input logic              ds0_n_i,
  input logic [5:0]        am_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              sel_o,
  input logic              beat_o,
  input logic              act_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << STEP_SHIFT;
  logic as_p, ds_p;
  logic seq_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      as_p <= 1'b1;
      ds_p <= 1'b1;
    end else begin
      as_p <= as_n_i;
      ds_p <= ds0_n_i;
    end
  end

  assign seq_code = (am_i == SEQ_AM0) || (am_i == SEQ_AM1);

  AST_SEQ_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_p && !as_n_i && seq_code) |=> (addr_o == $past(addr_i))); // R2
  AST_NONSEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_p && !as_n_i && !seq_code) |=> $stable(addr_o)); // R3
  AST_STEP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !as_n_i && !ds_p && ds0_n_i) |=> (addr_o == $past(addr_o) + STEP)); // R4
  AST_BEAT_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |-> sel_o); // R7
  AST_BEAT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> !beat_o); // R7
  AST_AS_HIGH_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_n_i |=> !sel_o); // R8
  AST_AS_HIGH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_n_i && as_p) |=> $stable(addr_o)); // R8
endmodule

bind seq_slave_cnt seq_slave_cnt_chk #(
  .ADDR_W(ADDR_W), .STEP_SHIFT(STEP_SHIFT), .SEQ_AM0(SEQ_AM0), .SEQ_AM1(SEQ_AM1)
) i_seq_slave_cnt_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .as_n_i(as_n_i), .ds0_n_i(ds0_n_i),
  .am_i(am_i), .addr_i(addr_i), .addr_o(addr_o), .sel_o(sel_o),
  .beat_o(beat_o), .act_q(act_q)
);

// File: tb/test_seq_slave_cnt.sv
module test_seq_slave_cnt;
  localparam int ADDR_W = 16;
  localparam int BASE   = 'h0100;
  localparam int LIMIT  = 'h01FF;
  localparam int STEP   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic as_n = 1'b1, ds_n = 1'b1, wr_n = 1'b1;
  logic [5:0] am = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [ADDR_W-1:0] addr_o;
  logic sel_o, beat_o, wr_o;

  int n_chk = 0, n_fail = 0;
  int exp_addr = 0;
  bit exp_act = 0;
  bit exp_wr = 0;

  always #5 clk = ~clk;

  seq_slave_cnt i_seq_slave_cnt (
    .clk_i(clk), .rst_ni(rst_n), .as_n_i(as_n), .ds0_n_i(ds_n), .wr_n_i(wr_n),
    .am_i(am), .addr_i(addr), .addr_o(addr_o), .sel_o(sel_o),
    .beat_o(beat_o), .wr_o(wr_o)
  );

  function automatic bit win(int a);
    return exp_act && a >= BASE && a <= LIMIT && ((a >> 1) & 1) == 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(int start, logic [5:0] code, int beats);
    am = code; addr = ADDR_W'(start); as_n = 1'b0;
    tick();
    addr = ~addr;  // no address after the first beat
    if (code == 6'h0B || code == 6'h0F) begin
      exp_act = 1; exp_addr = start;
    end
    chk("R2/R3 addr after strobe", addr_o, exp_addr);
    chk("R6 sel after load", sel_o, win(exp_addr));
    for (int i = 0; i < beats; i++) begin
      bit hit = win(exp_addr);
      wr_n = (i % 3 == 1);
      ds_n = 1'b0;
      tick();
      chk("R7 beat on ds fall", beat_o, hit);
      if (hit) begin
        exp_wr = !wr_n;
        chk("R7 wr_o direction", wr_o, exp_wr);
      end
      ds_n = 1'b1;
      tick();
      chk("R7 beat single pulse", beat_o, 0);
      if (exp_act) exp_addr = (exp_addr + STEP) & 'hFFFF;
      chk("R4/R5/R9 addr step", addr_o, exp_addr);
      chk("R6 sel per beat", sel_o, win(exp_addr));
    end
    as_n = 1'b1;
    tick();
    exp_act = 0;
    chk("R8 sel drops on as high", sel_o, 0);
    ds_n = 1'b0; tick(); ds_n = 1'b1; tick();
    chk("R8 ds ignored while as high", addr_o, exp_addr);
    chk("R8 no beat while as high", beat_o, 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset addr", addr_o, 0);
    chk("R1 reset sel", sel_o, 0);
    chk("R1 reset beat", beat_o, 0);
    chk("R1 reset wr", wr_o, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq('h00F8, 6'h0B, 8);   // R5 starts outside, enters window
    run_seq('h01F4, 6'h0F, 8);   // leaves window at the top
    run_seq('hFFFA, 6'h0B, 5);   // R9 wrap
    for (int s = 'h00FC; s <= 'h0106; s += 2) run_seq(s, 6'h0F, 3);
    run_seq('h0150, 6'h09, 3);   // R3 non-sequential code
    run_seq('h0150, 6'h3D, 2);   // R3 another non-sequential code
    run_seq('h0150, 6'h0B, 4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule